// File: doc/BRIEF.md
# Machine Security Configuration Register

This block holds three control bits that steer the memory-protection checker of a hart: a machine-mode lockdown enable, a default-deny enable for machine accesses that match no protection rule, and a bypass that lets software edit locked protection rules. The three bits leave the block as plain outputs and go to the permission checker and to the guard on protection-config writes.

Software reaches the register through a CSR write port at address 0x747, and only from machine privilege. Each bit has its own sticky behaviour. The two enables can be set but never cleared by software. The bypass can be set, and cleared once, after which it is frozen. The bypass is also frozen at 0 while any protection entry is locked. A dedicated protection-reset input returns all of this state to its safe default.

Top module: `secfg_reg`

## Requirements
- R1: A machine-privilege write (priv 2'b11) to address 0x747 with data bit 0 set makes the lockdown output 1 after the next clock edge. A later software write of 0 leaves it at 1.
- R2: A machine write to 0x747 with data bit 1 set makes the default-deny output 1 after the next clock edge. A later software write of 0 leaves it at 1.
- R3: `pmp_rst` high at a clock edge clears all three bits and the bypass-spent state. It takes priority over a write in the same cycle.
- R4: While no entry is locked and the bypass has not yet been cleared after a set, machine writes load data bit 2 into the bypass output.
- R5: While the bypass is 0 and `any_lock` is 1, writes to the bypass are ignored and it stays 0.
- R6: While the bypass is 1, a machine write of 0 to bit 2 clears it, even when `any_lock` is 1.
- R7: After the bypass has gone from 1 to 0 by a write, later writes cannot change it until `pmp_rst`.
- R8: A write to 0x747 at user (2'b00) or supervisor (2'b01) privilege changes no bit. It raises `illegal_o` for exactly the one cycle after the write edge.
- R9: While `csr_addr` is 0x747, `csr_rdata` holds lockdown in bit 0, default-deny in bit 1 and bypass in bit 2, with all higher bits zero. At any other address `csr_rdata` is zero, and writes there change nothing.
- R10: While `rst_n` is low, all bits and `illegal_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmp_rst | input | 1 | Synchronous protection reset that clears all sticky state |
| csr_addr | input | 12 | CSR address of the access |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write enable |
| csr_priv | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| any_lock | input | 1 | High when any protection entry has its lock bit set |
| csr_rdata | output | XLEN | Read data for the addressed register |
| lockdown_o | output | 1 | Machine-mode lockdown enable |
| dflt_deny_o | output | 1 | Default-deny for unmatched machine accesses |
| rule_bypass_o | output | 1 | Locked-rule edit bypass |
| illegal_o | output | 1 | One-cycle flag for a write attempted below machine privilege |

## Verification
The hardest state to reach is the spent bypass. It needs a set of the bypass followed by a clear, and only then can it be shown that a new set is refused. The lock freeze is similar: the same write must be refused with the bypass at 0 and accepted with the bypass at 1. The directed scenarios build these histories step by step. They run `pmp_rst` between scenarios, which also confirms that the reset clears the spent state.

// File: rtl/secfg_pkg.sv
package secfg_pkg;
  typedef enum logic [1:0] {
    PRV_U   = 2'b00,
    PRV_S   = 2'b01,
    PRV_RSV = 2'b10,
    PRV_M   = 2'b11
  } priv_e;

  localparam int unsigned BIT_LOCKDOWN = 0;
  localparam int unsigned BIT_DENY     = 1;
  localparam int unsigned BIT_BYPASS   = 2;
  localparam int unsigned NUM_BITS     = 3;
  localparam int unsigned NUM_SETONLY  = 2;
endpackage

// File: rtl/secfg_access.sv
module secfg_access
  import secfg_pkg::*;
#(
  parameter int unsigned AW   = 12,
  parameter logic [AW-1:0] ADDR = 12'h747
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [1:0]    priv,
  output logic          hit,
  output logic          wr_ok,
  output logic          illegal_q
);
  logic is_mach;
  logic illegal_d;

  assign hit     = (addr == ADDR);
  assign is_mach = (priv == PRV_M);
  assign wr_ok   = we && hit && is_mach;

  always_comb begin
    illegal_d = we && hit && !is_mach;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= illegal_d;
  end

  // R8: the flag lasts one cycle unless a new bad write arrives
  a_r8_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_q && !(we && hit && !is_mach)) |=> !illegal_q);
endmodule

// File: rtl/secfg_setonly_bit.sv
module secfg_setonly_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic pmp_rst,
  input  logic wr_en,
  input  logic wr_val,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = pmp_rst || (wr_en && wr_val);
    q_d  = pmp_rst ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end

  // R1 / R2: no software path clears the bit
  a_r1_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !pmp_rst) |=> q);
  // R3: the protection reset wins over a write
  a_r3_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pmp_rst |=> !q);
endmodule

// File: rtl/secfg_bypass_ctl.sv
module secfg_bypass_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pmp_rst,
  input  logic wr_en,
  input  logic wr_val,
  input  logic any_lock,
  output logic q
);
  logic spent_q;
  logic frozen;
  logic take;
  logic q_d;
  logic spent_d;

  always_comb begin
    frozen  = spent_q || (!q && any_lock);
    take    = wr_en && !frozen;
    q_d     = q;
    spent_d = spent_q;
    if (pmp_rst) begin
      q_d     = 1'b0;
      spent_d = 1'b0;
    end else if (take) begin
      q_d = wr_val;
      if (q && !wr_val) spent_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= 1'b0;
      spent_q <= 1'b0;
    end else begin
      q       <= q_d;
      spent_q <= spent_d;
    end
  end

  // R5: locked entries hold a cleared bypass at 0
  a_r5_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!q && any_lock && !pmp_rst) |=> !q);
  // R7: once spent, the bypass does not move until protection reset
  a_r7_spent_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spent_q && !pmp_rst) |=> (q == $past(q)));
  // R3: protection reset clears the bypass
  a_r3_bypass_reset: assert property (@(posedge clk) disable iff (!rst_n)
    pmp_rst |=> !q);
endmodule

// File: rtl/secfg_reg.sv
module secfg_reg
  import secfg_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 12,
  parameter logic [AW-1:0] ADDR = 12'h747
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pmp_rst,
  input  logic [AW-1:0]   csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  input  logic [1:0]      csr_priv,
  input  logic            any_lock,
  output logic [XLEN-1:0] csr_rdata,
  output logic            lockdown_o,
  output logic            dflt_deny_o,
  output logic            rule_bypass_o,
  output logic            illegal_o
);
  localparam int unsigned PAD = XLEN - NUM_BITS;

  logic                   hit;
  logic                   wr_ok;
  logic [NUM_SETONLY-1:0] so_q;
  logic [NUM_BITS-1:0]    bits;
  logic                   unused_wdata_hi;

  assign unused_wdata_hi = ^csr_wdata[XLEN-1:NUM_BITS];

  secfg_access #(.AW(AW), .ADDR(ADDR)) u_access (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (csr_addr),
    .we        (csr_we),
    .priv      (csr_priv),
    .hit       (hit),
    .wr_ok     (wr_ok),
    .illegal_q (illegal_o)
  );

  for (genvar i = 0; i < NUM_SETONLY; i++) begin : g_setonly
    secfg_setonly_bit u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .pmp_rst (pmp_rst),
      .wr_en   (wr_ok),
      .wr_val  (csr_wdata[i]),
      .q       (so_q[i])
    );
  end

  secfg_bypass_ctl u_bypass (
    .clk      (clk),
    .rst_n    (rst_n),
    .pmp_rst  (pmp_rst),
    .wr_en    (wr_ok),
    .wr_val   (csr_wdata[BIT_BYPASS]),
    .any_lock (any_lock),
    .q        (rule_bypass_o)
  );

  assign lockdown_o  = so_q[BIT_LOCKDOWN];
  assign dflt_deny_o = so_q[BIT_DENY];
  assign bits        = {rule_bypass_o, dflt_deny_o, lockdown_o};
  assign csr_rdata   = hit ? {{PAD{1'b0}}, bits} : '0;

  // R8: a low-privilege write changes nothing and raises the flag
  a_r8_lowpriv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && hit && csr_priv != PRV_M && !pmp_rst) |=>
      (illegal_o && bits == $past(bits)));
  // R9: a write to another address changes nothing
  a_r9_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !pmp_rst) |=> (bits == $past(bits)));
endmodule

// File: tb/secfg_reg_bench.sv
module secfg_reg_bench;
  localparam int unsigned XLEN = 64;
  localparam time CLK_PERIOD = 10ns;

  logic            clk;
  logic            rst_n;
  logic            pmp_rst;
  logic [11:0]     csr_addr;
  logic [XLEN-1:0] csr_wdata;
  logic            csr_we;
  logic [1:0]      csr_priv;
  logic            any_lock;
  logic [XLEN-1:0] csr_rdata;
  logic            lockdown_o, dflt_deny_o, rule_bypass_o, illegal_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  secfg_reg u_secfg_reg (
    .clk(clk), .rst_n(rst_n), .pmp_rst(pmp_rst), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_we(csr_we), .csr_priv(csr_priv),
    .any_lock(any_lock), .csr_rdata(csr_rdata), .lockdown_o(lockdown_o),
    .dflt_deny_o(dflt_deny_o), .rule_bypass_o(rule_bypass_o),
    .illegal_o(illegal_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {rule_bypass_o, dflt_deny_o, lockdown_o};
  endfunction

  // drive at negedge, one posedge, back to idle at the following negedge
  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d,
                    input logic [1:0] p);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_priv = p; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0; csr_addr = 12'h747; csr_wdata = '0; csr_priv = 2'b11;
  endtask

  task automatic prot_reset(input logic with_write);
    @(negedge clk);
    pmp_rst = 1'b1;
    if (with_write) begin
      csr_we = 1'b1; csr_wdata = 64'h7; csr_priv = 2'b11; csr_addr = 12'h747;
    end
    @(negedge clk);
    pmp_rst = 1'b0; csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic t_reset_state();
    chk("R10 outputs after reset", {61'd0, outs()}, 64'd0);
    chk("R10 illegal after reset", {63'd0, illegal_o}, 64'd0);
  endtask

  task automatic t_setonly();
    wr(12'h747, 64'h1, 2'b11);
    chk("R1 lockdown set", {61'd0, outs()}, 64'h1);
    wr(12'h747, 64'h0, 2'b11);
    chk("R1 lockdown not clearable", {63'd0, lockdown_o}, 64'h1);
    wr(12'h747, 64'h2, 2'b11);
    chk("R2 deny set", {61'd0, outs()}, 64'h3);
    wr(12'h747, 64'h0, 2'b11);
    chk("R2 deny not clearable", {63'd0, dflt_deny_o}, 64'h1);
    prot_reset(1'b0);
    chk("R3 reset clears", {61'd0, outs()}, 64'h0);
  endtask

  task automatic t_reset_priority();
    prot_reset(1'b1);
    chk("R3 reset beats write", {61'd0, outs()}, 64'h0);
  endtask

  task automatic t_bypass_free();
    any_lock = 1'b0;
    wr(12'h747, 64'h4, 2'b11);
    chk("R4 bypass set", {63'd0, rule_bypass_o}, 64'h1);
    wr(12'h747, 64'h0, 2'b11);
    chk("R4 bypass cleared", {63'd0, rule_bypass_o}, 64'h0);
    wr(12'h747, 64'h4, 2'b11);
    chk("R7 spent bypass refuses set", {63'd0, rule_bypass_o}, 64'h0);
    prot_reset(1'b0);
    wr(12'h747, 64'h4, 2'b11);
    chk("R3 reset clears spent state", {63'd0, rule_bypass_o}, 64'h1);
    prot_reset(1'b0);
  endtask

  task automatic t_bypass_lock();
    any_lock = 1'b1;
    wr(12'h747, 64'h4, 2'b11);
    chk("R5 lock freezes bypass at 0", {63'd0, rule_bypass_o}, 64'h0);
    any_lock = 1'b0;
    wr(12'h747, 64'h4, 2'b11);
    any_lock = 1'b1;
    wr(12'h747, 64'h4, 2'b11);
    chk("R6 bypass held while locked", {63'd0, rule_bypass_o}, 64'h1);
    wr(12'h747, 64'h0, 2'b11);
    chk("R6 bypass clearable while locked", {63'd0, rule_bypass_o}, 64'h0);
    any_lock = 1'b0;
    prot_reset(1'b0);
  endtask

  task automatic t_lowpriv();
    @(negedge clk);
    csr_addr = 12'h747; csr_wdata = 64'h7; csr_priv = 2'b00; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0; csr_priv = 2'b11;
    chk("R8 illegal after user write", {63'd0, illegal_o}, 64'h1);
    chk("R8 user write ignored", {61'd0, outs()}, 64'h0);
    @(negedge clk);
    chk("R8 illegal lasts one cycle", {63'd0, illegal_o}, 64'h0);
    wr(12'h747, 64'h7, 2'b01);
    chk("R8 supervisor write ignored", {61'd0, outs()}, 64'h0);
  endtask

  task automatic t_read();
    wr(12'h746, 64'h7, 2'b11);
    chk("R9 other address write ignored", {61'd0, outs()}, 64'h0);
    wr(12'h747, 64'hFFFF_FFFF_FFFF_FFFB, 2'b11);
    chk("R9 read layout", csr_rdata, 64'h3);
    wr(12'h747, 64'h4, 2'b11);
    chk("R9 read all bits", csr_rdata, 64'h7);
    @(negedge clk);
    csr_addr = 12'h300;
    #1;
    chk("R9 other address reads zero", csr_rdata, 64'h0);
    csr_addr = 12'h747;
    prot_reset(1'b0);
  endtask

  initial begin
    rst_n = 1'b0; pmp_rst = 1'b0; csr_addr = 12'h747; csr_wdata = '0;
    csr_we = 1'b0; csr_priv = 2'b11; any_lock = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_setonly();
    t_reset_priority();
    t_bypass_free();
    t_bypass_lock();
    t_lowpriv();
    t_read();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule